// File: doc/BRIEF.md
# Ping-Pong Audio Capture Write Engine

This block takes a stream of already-packed 32-bit audio words and writes them into memory through a simple valid/ready write port. It fills two buffers in turn. Software programs a base address for each buffer and a buffer length counted in samples. When the active buffer has received that many samples, its full flag rises, an interrupt can fire, and writing continues at the start of the other buffer. Software empties a buffer and then acknowledges it so that the buffer can be filled again.

A small register port controls the engine. Through it software sets the two bases, the length, a run bit, the sample format, per-condition interrupt enables and write-one acknowledge bits. Writing the single key value to the control register returns the whole unit to its reset state. The format tells the engine how many samples each packed word carries, and the sample count advances by that amount.

Two faults are reported. An overrun is raised when a buffer completes while the other buffer is still unacknowledged; the engine then drops words until a buffer is freed. A bandwidth error is raised when a word arrives while the previous memory write is still waiting for the port.

Top module: `acap_dma`

## Requirements
- R1: After hardware reset, and after a write of exactly 0x80000000 to the control register (address 1), run is 0, format, interrupt enables, both bases and the length are 0, all flags are 0 and buffer A is active. A control write that has bit 31 set alongside any other bit is an ordinary control write.
- R2: Register word addresses: 0 status (read only; writes are ignored), 1 control, 2 base A, 3 base B, 4 length. Addresses 5 to 7 read 0. The length register keeps only its low SIZE_W bits. Control reads back run in bit 0, format in bits 2:1 and the enables in bits 7:4; every other bit reads 0.
- R3: Bits 5:0 of both base registers always read 0, so every buffer starts on a 64-byte boundary.
- R4: The k-th word accepted into a buffer (k counted from 0) is presented on the memory port at base + 4*k with its data unchanged, one cycle after it is taken.
- R5: Format codes in control bits 2:1 give the samples per word: 0 stereo 16-bit gives 1, 1 stereo 8-bit gives 2, 2 mono 16-bit gives 2, 3 mono 8-bit gives 4. A buffer completes on the word that brings its sample count to the length or beyond; before that its full flag stays 0.
- R6: On completion the buffer's full flag is set (status bit 0 for A, bit 1 for B) and, if the other buffer is not full, the other buffer becomes active (status bit 4 is 1 while A is active) and the next word goes to its base.
- R7: If the other buffer is still full when a buffer completes, the overrun flag (status bit 2) is set, the active buffer does not change and incoming words are dropped with no memory write. Once an acknowledge frees a buffer, that buffer becomes active and writing restarts at its base.
- R8: Writing 1 to control bits 8, 9, 10 or 11 clears full A, full B, overrun or bandwidth error. If the same condition is raised in the same cycle, the flag stays set.
- R9: The interrupt output is 1 exactly when some status flag in bits 3:0 is set and its enable (the same position in control bits 7:4) is 1.
- R10: A word that arrives while the previous memory write is still waiting for ready sets the bandwidth-error flag (status bit 3) and is dropped; the waiting write keeps its address and data.
- R11: While run is 0, incoming words are ignored: no memory write and no change to the count or the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on the clock |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| in_valid | input | 1 | A packed word is present this cycle |
| in_data | input | 32 | Packed audio word |
| mem_valid | output | 1 | Memory write request pending |
| mem_addr | output | ADDR_W | Byte address of the write |
| mem_data | output | 32 | Write data |
| mem_ready | input | 1 | Memory port takes the write this cycle |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W = 16 and SIZE_W = 6, which keeps the lengths small enough to sweep every format against every length from 1 to 6, including lengths that end partway through a packed word. Each sweep point runs three buffer fills, so both the A-to-B and B-to-A switches and the address restart are seen under every format. The narrow widths also make the masking of the base and length registers visible on readback. Separate sequences force an overrun with both buffers full, a stalled memory port, a set and an acknowledge in the same cycle, and a stopped engine.

// File: rtl/acap_pkg.sv
package acap_pkg;

   // Sample layout carried by each packed input word
   typedef enum logic [1:0] {
      FMT_ST16 = 2'd0,
      FMT_ST8  = 2'd1,
      FMT_MO16 = 2'd2,
      FMT_MO8  = 2'd3
   } fmt_e;

   // Register word addresses
   localparam logic [2:0] RA_STAT  = 3'd0;
   localparam logic [2:0] RA_CTRL  = 3'd1;
   localparam logic [2:0] RA_BASEA = 3'd2;
   localparam logic [2:0] RA_BASEB = 3'd3;
   localparam logic [2:0] RA_SIZE  = 3'd4;

   localparam logic [31:0] SOFT_RESET_KEY = 32'h8000_0000;

   // Flag vector positions (status bits 3:0, enables 7:4, acks 11:8)
   localparam int FL_FULL_A = 0;
   localparam int FL_FULL_B = 1;
   localparam int FL_OVR    = 2;
   localparam int FL_BW     = 3;
   localparam int NUM_FLAGS = 4;

   localparam int BASE_ALIGN_BITS = 6;

   function automatic logic [2:0] samples_per_word(input fmt_e f);
      case (f)
         FMT_ST16: return 3'd1;
         FMT_ST8:  return 3'd2;
         FMT_MO16: return 3'd2;
         default:  return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/acap_regs.sv
module acap_regs
   import acap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_wr,
   input  logic [2:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [NUM_FLAGS-1:0] flag_set,
   input  logic                 a_active,
   output logic                 run,
   output fmt_e                 fmt,
   output logic [ADDR_W-1:0]    base_a,
   output logic [ADDR_W-1:0]    base_b,
   output logic [SIZE_W-1:0]    size,
   output logic [NUM_FLAGS-1:0] ie,
   output logic [NUM_FLAGS-1:0] flags,
   output logic                 soft_rst
);

   localparam int BQ_W = ADDR_W - BASE_ALIGN_BITS;

   logic                 ctrl_wr;
   logic [NUM_FLAGS-1:0] ack;
   logic [BQ_W-1:0]      base_a_q;
   logic [BQ_W-1:0]      base_b_q;

   assign ctrl_wr  = reg_wr && (reg_addr == RA_CTRL);
   assign soft_rst = ctrl_wr && (reg_wdata == SOFT_RESET_KEY);
   assign ack      = (ctrl_wr && !soft_rst) ? reg_wdata[11:8] : '0;

   assign base_a = {base_a_q, {BASE_ALIGN_BITS{1'b0}}};
   assign base_b = {base_b_q, {BASE_ALIGN_BITS{1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         run      <= 1'b0;
         fmt      <= FMT_ST16;
         ie       <= '0;
         base_a_q <= '0;
         base_b_q <= '0;
         size     <= '0;
      end else if (reg_wr) begin
         case (reg_addr)
            RA_CTRL: begin
               run <= reg_wdata[0];
               fmt <= fmt_e'(reg_wdata[2:1]);
               ie  <= reg_wdata[7:4];
            end
            RA_BASEA: base_a_q <= reg_wdata[ADDR_W-1:BASE_ALIGN_BITS];
            RA_BASEB: base_b_q <= reg_wdata[ADDR_W-1:BASE_ALIGN_BITS];
            RA_SIZE:  size     <= reg_wdata[SIZE_W-1:0];
            default:  ;
         endcase
      end
   end

   // One sticky flag per condition: raise wins over acknowledge
   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk) begin
         if (!rst_n || soft_rst) q <= 1'b0;
         else if (flag_set[i])   q <= 1'b1;
         else if (ack[i])        q <= 1'b0;
      end
      assign flags[i] = q;

      AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
         (ack[i] && !flag_set[i]) |=> !flags[i]);   // R8
      AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
         (flag_set[i] && !soft_rst) |=> flags[i]);   // R8
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_STAT:  reg_rdata[4:0] = {a_active, flags};
         RA_CTRL:  reg_rdata[7:0] = {ie, 1'b0, fmt, run};
         RA_BASEA: reg_rdata[ADDR_W-1:0] = base_a;
         RA_BASEB: reg_rdata[ADDR_W-1:0] = base_b;
         RA_SIZE:  reg_rdata[SIZE_W-1:0] = size;
         default:  reg_rdata = '0;
      endcase
   end

   AST_KEY_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!run && base_a == '0 && base_b == '0 && size == '0 && flags == '0));   // R1

endmodule

// File: rtl/acap_engine.sv
module acap_engine
   import acap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst,
   input  logic                 run,
   input  fmt_e                 fmt,
   input  logic [ADDR_W-1:0]    base_a,
   input  logic [ADDR_W-1:0]    base_b,
   input  logic [SIZE_W-1:0]    size,
   input  logic                 full_a,
   input  logic                 full_b,
   input  logic                 in_valid,
   input  logic [31:0]          in_data,
   output logic                 mem_valid,
   output logic [ADDR_W-1:0]    mem_addr,
   output logic [31:0]          mem_data,
   input  logic                 mem_ready,
   output logic                 a_active,
   output logic [NUM_FLAGS-1:0] flag_set
);

   localparam int CNT_W = SIZE_W + 1;
   localparam int OFF_W = SIZE_W;

   logic              act_b;
   logic [CNT_W-1:0]  cnt;
   logic [CNT_W-1:0]  cnt_nx;
   logic [OFF_W-1:0]  off;
   logic              pending;
   logic              take;
   logic              acc;
   logic              done;
   logic              full_act;
   logic              full_oth;
   logic [ADDR_W-1:0] wr_addr;

   assign pending  = mem_valid && !mem_ready;
   assign take     = run && in_valid;
   assign full_act = act_b ? full_b : full_a;
   assign full_oth = act_b ? full_a : full_b;
   assign acc      = take && !pending && !full_act;
   assign cnt_nx   = cnt + CNT_W'(samples_per_word(fmt));
   assign done     = acc && (cnt_nx >= CNT_W'(size));
   assign wr_addr  = (act_b ? base_b : base_a) + ADDR_W'({off, 2'b00});
   assign a_active = !act_b;

   always_comb begin
      flag_set            = '0;
      flag_set[FL_FULL_A] = done && !act_b;
      flag_set[FL_FULL_B] = done && act_b;
      flag_set[FL_OVR]    = done && full_oth;
      flag_set[FL_BW]     = take && pending;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         mem_valid <= 1'b0;
         mem_addr  <= '0;
         mem_data  <= '0;
      end else if (acc) begin
         mem_valid <= 1'b1;
         mem_addr  <= wr_addr;
         mem_data  <= in_data;
      end else if (mem_ready) begin
         mem_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         act_b <= 1'b0;
         cnt   <= '0;
         off   <= '0;
      end else if (acc) begin
         if (done) begin
            cnt <= '0;
            off <= '0;
            if (!full_oth) act_b <= !act_b;
         end else begin
            cnt <= cnt_nx;
            off <= off + OFF_W'(1);
         end
      end else if (full_act && !full_oth) begin
         act_b <= !act_b;   // a buffer was freed after a stall
      end
   end

   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (mem_addr[1:0] == 2'b00));   // R3
   AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (pending && !soft_rst) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));   // R10
   AST_SWITCH_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !full_oth && !soft_rst) |=> (act_b != $past(act_b)));   // R6
   AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_valid && full_act && !soft_rst) |=> !mem_valid);   // R7
   AST_IDLE_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_valid && !run) |=> !mem_valid);   // R11

endmodule

// File: rtl/acap_irq.sv
module acap_irq #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] flags,
   input  logic [N-1:0] ie,
   output logic         irq
);

   logic [N-1:0] hit;

   for (genvar i = 0; i < N; i++) begin : g_src
      assign hit[i] = flags[i] && ie[i];

      AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
         ($rose(flags[i]) && ie[i]) |-> irq);   // R9
   end

   assign irq = |hit;

   AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != '0));   // R9

endmodule

// File: rtl/acap_dma.sv
module acap_dma
   import acap_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int SIZE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [2:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic              in_valid,
   input  logic [31:0]       in_data,
   output logic              mem_valid,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [31:0]       mem_data,
   input  logic              mem_ready,
   output logic              irq
);

   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
      $error("acap_dma: ADDR_W must lie in 8..32");
   end
   if (SIZE_W < 1 || SIZE_W > 30) begin : g_bad_size_w
      $error("acap_dma: SIZE_W must lie in 1..30");
   end
   if (SIZE_W + 2 > ADDR_W) begin : g_bad_span
      $error("acap_dma: a full buffer must fit in the address space");
   end

   logic                 run;
   fmt_e                 fmt;
   logic [ADDR_W-1:0]    base_a;
   logic [ADDR_W-1:0]    base_b;
   logic [SIZE_W-1:0]    size;
   logic [NUM_FLAGS-1:0] ie;
   logic [NUM_FLAGS-1:0] flags;
   logic [NUM_FLAGS-1:0] flag_set;
   logic                 soft_rst;
   logic                 a_active;

   acap_regs #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .flag_set  (flag_set),
      .a_active  (a_active),
      .run       (run),
      .fmt       (fmt),
      .base_a    (base_a),
      .base_b    (base_b),
      .size      (size),
      .ie        (ie),
      .flags     (flags),
      .soft_rst  (soft_rst)
   );

   acap_engine #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .run       (run),
      .fmt       (fmt),
      .base_a    (base_a),
      .base_b    (base_b),
      .size      (size),
      .full_a    (flags[FL_FULL_A]),
      .full_b    (flags[FL_FULL_B]),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .mem_valid (mem_valid),
      .mem_addr  (mem_addr),
      .mem_data  (mem_data),
      .mem_ready (mem_ready),
      .a_active  (a_active),
      .flag_set  (flag_set)
   );

   acap_irq #(.N(NUM_FLAGS)) u_irq (
      .clk   (clk),
      .rst_n (rst_n),
      .flags (flags),
      .ie    (ie),
      .irq   (irq)
   );

endmodule

// File: tb/sim_acap_dma.sv
module sim_acap_dma;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 16;
   localparam int SW = 6;
   localparam logic [31:0] KEY = 32'h8000_0000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [2:0]    reg_addr = '0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          in_valid = 1'b0;
   logic [31:0]   in_data = '0;
   logic          mem_valid;
   logic [AW-1:0] mem_addr;
   logic [31:0]   mem_data;
   logic          mem_ready = 1'b1;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;

   acap_dma #(.ADDR_W(AW), .SIZE_W(SW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_valid(in_valid),
      .in_data(in_data), .mem_valid(mem_valid), .mem_addr(mem_addr),
      .mem_data(mem_data), .mem_ready(mem_ready), .irq(irq)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic chk_rd(input string req, input logic [2:0] a, input logic [31:0] exp);
      reg_addr = a;
      #1;
      chk(req, reg_rdata, exp);
   endtask

   task automatic send(input logic [31:0] d);
      @(negedge clk);
      in_valid = 1'b1; in_data = d;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic cfg(input logic [31:0] ba, input logic [31:0] bb,
                      input logic [31:0] sz, input logic [31:0] ctrl);
      wr(3'd1, KEY);
      wr(3'd2, ba);
      wr(3'd3, bb);
      wr(3'd4, sz);
      wr(3'd1, ctrl);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: hardware reset state
      chk_rd("R1 status after reset", 3'd0, 32'h10);
      chk_rd("R1 control after reset", 3'd1, 32'h0);
      chk_rd("R1 length after reset", 3'd4, 32'h0);
      chk("R1 no write after reset", {31'b0, mem_valid}, 32'h0);
      chk("R1 irq after reset", {31'b0, irq}, 32'h0);

      // R2: map, undefined addresses, read-only status, masking
      for (int a = 5; a < 8; a++) chk_rd("R2 undefined address reads 0", 3'(a), 32'h0);
      wr(3'd0, 32'hFFFF_FFFF);
      chk_rd("R2 status write ignored", 3'd0, 32'h10);
      wr(3'd1, 32'h0000_0FF7);
      chk_rd("R2 control readback", 3'd1, 32'h0000_00F7);
      wr(3'd4, 32'h0000_FFFF);
      chk_rd("R2 length keeps SIZE_W bits", 3'd4, 32'h3F);
      wr(3'd2, 32'hFFFF_FFFF);
      chk_rd("R3 base A low bits zero", 3'd2, 32'h0000_FFC0);
      wr(3'd3, 32'h0000_123F);
      chk_rd("R3 base B low bits zero", 3'd3, 32'h0000_1200);

      // R1: bit 31 with other bits is an ordinary write; exact key resets
      wr(3'd1, 32'h8000_0001);
      chk_rd("R1 non-key control write", 3'd1, 32'h1);
      chk_rd("R1 non-key keeps base", 3'd2, 32'h0000_FFC0);
      wr(3'd1, KEY);
      chk_rd("R1 key clears base A", 3'd2, 32'h0);
      chk_rd("R1 key clears base B", 3'd3, 32'h0);
      chk_rd("R1 key clears length", 3'd4, 32'h0);
      chk_rd("R1 key clears control", 3'd1, 32'h0);
      chk_rd("R1 key status", 3'd0, 32'h10);

      // R4/R5/R6/R8/R9: sweep formats and lengths over three fills
      for (int f = 0; f < 4; f++) begin
         for (int s = 1; s <= 6; s++) begin
            int spw = (f == 0) ? 1 : ((f == 3) ? 4 : 2);
            int wpb = (s + spw - 1) / spw;
            logic [31:0] baw = 32'h1000 + 32'(f) * 32'h100 + 32'h2B;
            logic [31:0] bbw = 32'h4000 + 32'(s) * 32'h40 + 32'h15;
            logic [31:0] bae = baw & ~32'h3F;
            logic [31:0] bbe = bbw & ~32'h3F;
            logic [3:0]  iev = (f % 2 == 0) ? 4'hF : 4'h0;
            logic [31:0] ctrlv = 32'h1 | (32'(f) << 1) | (32'(iev) << 4);
            cfg(baw, bbw, 32'(s), ctrlv);
            chk_rd("R3 sweep base A", 3'd2, bae);
            for (int j = 0; j < 3 * wpb; j++) begin
               int bsel = (j / wpb) % 2;
               int k = j % wpb;
               logic [31:0] dat = 32'hA000_0000 + (32'(f) << 16) + (32'(s) << 8) + 32'(j);
               logic [31:0] ea = ((bsel == 1) ? bbe : bae) + 32'(4 * k);
               send(dat);
               chk("R4 write valid", {31'b0, mem_valid}, 32'h1);
               chk("R4 write address", 32'(mem_addr), ea);
               chk("R4 write data", mem_data, dat);
               if (k == wpb - 1) begin
                  chk_rd("R6 full flag and switch", 3'd0,
                         (32'h1 << bsel) | ((bsel == 1) ? 32'h10 : 32'h0));
                  chk("R9 irq on full", {31'b0, irq}, {31'b0, (iev != 4'h0)});
                  wr(3'd1, ctrlv | (32'h1 << (8 + bsel)));
                  chk_rd("R8 ack clears full", 3'd0, (bsel == 1) ? 32'h10 : 32'h0);
                  chk("R9 irq after ack", {31'b0, irq}, 32'h0);
               end else begin
                  chk_rd("R5 not yet full", 3'd0, (bsel == 0) ? 32'h10 : 32'h0);
               end
            end
         end
      end

      // R7: overrun with both buffers full
      cfg(32'h2000, 32'h3000, 32'd2, 32'hF1);
      send(32'h11); chk("R4 ovr seq A0", 32'(mem_addr), 32'h2000);
      send(32'h12); chk("R4 ovr seq A1", 32'(mem_addr), 32'h2004);
      send(32'h13); chk("R6 ovr seq B0", 32'(mem_addr), 32'h3000);
      send(32'h14); chk("R6 ovr seq B1", 32'(mem_addr), 32'h3004);
      chk_rd("R7 overrun status", 3'd0, 32'h07);
      chk("R9 irq on overrun", {31'b0, irq}, 32'h1);
      send(32'h55);
      chk("R7 word dropped", {31'b0, mem_valid}, 32'h0);
      chk_rd("R7 status held", 3'd0, 32'h07);
      wr(3'd1, 32'h1F1);
      @(negedge clk);
      chk_rd("R7 freed buffer active", 3'd0, 32'h16);
      send(32'h66);
      chk("R7 restart valid", {31'b0, mem_valid}, 32'h1);
      chk("R7 restart at base A", 32'(mem_addr), 32'h2000);
      chk("R7 restart data", mem_data, 32'h66);
      wr(3'd1, 32'h6F1);
      chk_rd("R8 ack overrun and B", 3'd0, 32'h10);

      // R10: stalled memory port
      cfg(32'h2000, 32'h3000, 32'd8, 32'h01);
      mem_ready = 1'b0;
      send(32'h111);
      chk("R10 first write", 32'(mem_addr), 32'h2000);
      send(32'h222);
      chk_rd("R10 bandwidth flag", 3'd0, 32'h18);
      chk("R10 held address", 32'(mem_addr), 32'h2000);
      chk("R10 held data", mem_data, 32'h111);
      chk("R10 still pending", {31'b0, mem_valid}, 32'h1);
      mem_ready = 1'b1;
      @(negedge clk);
      chk("R10 write drained", {31'b0, mem_valid}, 32'h0);
      send(32'h333);
      chk("R10 dropped word not counted", 32'(mem_addr), 32'h2004);
      chk("R10 next data", mem_data, 32'h333);

      // R8: raise and acknowledge in the same cycle
      cfg(32'h2000, 32'h3000, 32'd1, 32'h01);
      @(negedge clk);
      in_valid = 1'b1; in_data = 32'h77;
      reg_addr = 3'd1; reg_wdata = 32'h101; reg_wr = 1'b1;
      @(negedge clk);
      in_valid = 1'b0; reg_wr = 1'b0;
      chk_rd("R8 set wins over ack", 3'd0, 32'h01);

      // R11: stopped engine ignores words
      cfg(32'h2000, 32'h3000, 32'd1, 32'h00);
      send(32'h88);
      chk("R11 no write while stopped", {31'b0, mem_valid}, 32'h0);
      chk_rd("R11 flags unchanged", 3'd0, 32'h10);
      wr(3'd1, 32'h01);
      send(32'h99);
      chk("R11 first word after start", 32'(mem_addr), 32'h2000);
      chk_rd("R11 count untouched by ignored word", 3'd0, 32'h01);

      summary();
      $finish;
   end

endmodule